// File: doc/BRIEF.md
# Parallel Port Strobe Handshake Controller

This block sits between a simple register bus and two byte-wide parallel ports. One port is output-only. The other port is bidirectional, and each of its lines has a driver enable. A strobe input lets an external device tell the block that data is ready or has been taken. A strobe output tells that device that the block has data or has room for data. The device on the other end of the port can therefore exchange bytes under strobe control and does not need to be polled.

The control register selects one of three operating styles:

- **Simple strobed.** Every active input-strobe edge captures the bidirectional port into a latch. Every write to the output-only port produces an output-strobe pulse.
- **Input handshake.** The same capture happens, and the output strobe signals that the latch is free.
- **Output handshake.** The output strobe announces data written to the bidirectional port. The input strobe acts as the acknowledge, and while it is at its active level it also forces that port's drivers on.

A status flag records every active strobe edge. Software clears the flag with a two-step access: it reads the control register while the flag reads 1, then it accesses the latched-data register.

Top module: `pio_strobe_hs`

## Requirements
- R1: After reset the following hold: control register fields are 0, flag is 0, `pb_o` is 0, DDR is 0, `pc_oe` is 0 and `strb_o` is 0.
- R2: Bus addresses are 0 = control/status, 1 = output port, 2 = latched data, 3 = direction register. Control bits are: bit 0 handshake enable, bit 1 output-handshake select, bit 2 pulse select (1 = pulse, 0 = level), bit 3 edge select (1 = rising edge and high active level, 0 = falling edge and low active level). Bit 7 is the read-only flag. Bits 6:4 read as 0.
- R3: `stra_i` passes through SYNC_STAGES flip-flops before edge detection. On each active edge, `pc_i` is captured into the latch (read at address 2) and the flag is set in the same cycle. An inactive edge changes neither the latch nor the flag.
- R4: In simple strobed mode, each write to address 1 drives `strb_o` high for exactly PULSE_CYCLES cycles, starting the cycle after the write.
- R5: In both input modes, the flag clears after a read of address 0 that saw the flag at 1 is followed by a read of address 2. A read of address 2 without that preceding status read leaves the flag set.
- R6: Any access to address 1, 2 or 3 between the arming status read and the completing access cancels the armed state, and the flag stays set.
- R7: In output handshake mode, the completing access is a write to address 2. A read of address 2 does not clear the flag in this mode.
- R8: In output handshake mode, `pc_oe` is all ones while the synchronized strobe input is at its active level. In every other case `pc_oe` equals the direction register.
- R9: In handshake level mode, `strb_o` equals the inverted flag in input handshake. In output handshake it rises on a write to address 2 and falls on the next active strobe edge. In handshake pulse mode, the completing latched-data read (input) or a write to address 2 (output) produces a PULSE_CYCLES pulse.
- R10: In both handshake modes, writes to address 1 update `pb_o` and produce no strobe pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reads have side effects) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational on addr |
| pc_i | input | DATA_W | Bidirectional port pin levels |
| pc_o | output | DATA_W | Bidirectional port output data |
| pc_oe | output | DATA_W | Bidirectional port driver enables |
| pb_o | output | DATA_W | Output-only port data |
| stra_i | input | 1 | Strobe input pin |
| strb_o | output | 1 | Strobe output pin, active high |

## Verification
The bench builds the block with SYNC_STAGES = 3 and PULSE_CYCLES = 3. This exercises a synchronizer deeper than the minimum and selects the counter variant of the strobe generator rather than the single-flop one. The bench derives every capture and pulse window from these two values, so an off-by-one in the chain or the counter shows up as a wrong sample cycle. Each mode is driven through the arm, cancel and clear paths of the flag sequence.

// File: rtl/pio_hs_pkg.sv
package pio_hs_pkg;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_OUTB = 2'd1,
      REG_PCL  = 2'd2,
      REG_DIRC = 2'd3
   } pio_reg_e;

   typedef struct packed {
      logic edge_rise;
      logic pulse_mode;
      logic out_sel;
      logic hs_en;
   } pio_ctrl_t;

   localparam int CTRL_BITS = 4;

endpackage

// File: rtl/pio_hs_sync_edge.sv
module pio_hs_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic rise_sel_i,
   output logic level_o,
   output logic edge_o,
   output logic active_o
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("pio_hs_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o  = chain_q[STAGES-1];
   assign edge_o   = rise_sel_i ? (level_o & ~prev_q) : (~level_o & prev_q);
   assign active_o = (level_o == rise_sel_i);

endmodule

// File: rtl/pio_hs_flag.sv
module pio_hs_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic ctrl_rd_i,
   input  logic other_acc_i,
   input  logic clr_acc_i,
   output logic flag_o,
   output logic clr_done_o
);

   logic armed_q;

   assign clr_done_o = armed_q & clr_acc_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (set_i)           flag_o <= 1'b1;
         else if (clr_done_o) flag_o <= 1'b0;

         if (ctrl_rd_i && flag_o) armed_q <= 1'b1;
         else if (other_acc_i)    armed_q <= 1'b0;
      end
   end

   assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);

   assert_hold_unarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !armed_q && !set_i) |=> flag_o);

   assert_clear_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && clr_acc_i && !set_i) |=> !flag_o);

   assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (other_acc_i && !ctrl_rd_i) |=> !armed_q);

endmodule

// File: rtl/pio_hs_strobe_out.sv
module pio_hs_strobe_out #(
   parameter int PULSE_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   input  logic use_level_i,
   input  logic level_i,
   output logic strb_o
);

   localparam int CW = $clog2(PULSE_CYCLES + 1);

   logic pulse;

   generate
      if (PULSE_CYCLES < 1) begin : g_bad_len
         $error("pio_hs_strobe_out: PULSE_CYCLES must be at least 1");
      end
      if (PULSE_CYCLES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse <= 1'b0;
            else        pulse <= trig_i;
         end
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (trig_i)         cnt_q <= CW'(PULSE_CYCLES);
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end
         assign pulse = (cnt_q != '0);
      end
   endgenerate

   assign strb_o = use_level_i ? level_i : pulse;

   assert_pulse_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i |=> pulse);

endmodule

// File: rtl/pio_strobe_hs.sv
module pio_strobe_hs
   import pio_hs_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int PULSE_CYCLES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] pc_i,
   output logic [DATA_W-1:0] pc_o,
   output logic [DATA_W-1:0] pc_oe,
   output logic [DATA_W-1:0] pb_o,
   input  logic              stra_i,
   output logic              strb_o
);

   generate
      if (DATA_W < CTRL_BITS + 1) begin : g_bad_width
         $error("pio_strobe_hs: DATA_W too narrow for the control register");
      end
   endgenerate

   pio_ctrl_t         ctrl_q;
   logic [DATA_W-1:0] ddr_q;
   logic [DATA_W-1:0] lat_q;
   logic              olvl_q;

   logic stra_lvl, stra_edge, stra_act;
   logic flag, clr_done;

   wire sel_ctrl = (addr == REG_CTRL);
   wire sel_outb = (addr == REG_OUTB);
   wire sel_pcl  = (addr == REG_PCL);
   wire sel_dirc = (addr == REG_DIRC);

   wire out_hs  = ctrl_q.hs_en & ctrl_q.out_sel;
   wire pb_wr   = wr_en & sel_outb;
   wire pcl_wr  = wr_en & sel_pcl;
   wire pcl_rd  = rd_en & sel_pcl;

   pio_hs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (stra_i),
      .rise_sel_i (ctrl_q.edge_rise),
      .level_o    (stra_lvl),
      .edge_o     (stra_edge),
      .active_o   (stra_act)
   );

   pio_hs_flag u_flag (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (stra_edge),
      .ctrl_rd_i   (rd_en & sel_ctrl),
      .other_acc_i ((rd_en | wr_en) & ~sel_ctrl),
      .clr_acc_i   (out_hs ? pcl_wr : pcl_rd),
      .flag_o      (flag),
      .clr_done_o  (clr_done)
   );

   wire strb_trig = (~ctrl_q.hs_en & pb_wr)
                  | (ctrl_q.hs_en & ctrl_q.pulse_mode & (ctrl_q.out_sel ? pcl_wr : clr_done));

   pio_hs_strobe_out #(.PULSE_CYCLES(PULSE_CYCLES)) u_strb (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_i      (strb_trig),
      .use_level_i (ctrl_q.hs_en & ~ctrl_q.pulse_mode),
      .level_i     (ctrl_q.out_sel ? olvl_q : ~flag),
      .strb_o      (strb_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ddr_q  <= '0;
         pb_o   <= '0;
         pc_o   <= '0;
         lat_q  <= '0;
         olvl_q <= 1'b0;
      end else begin
         if (wr_en && sel_ctrl) ctrl_q <= pio_ctrl_t'(wdata[CTRL_BITS-1:0]);
         if (wr_en && sel_dirc) ddr_q  <= wdata;
         if (pb_wr)             pb_o   <= wdata;
         if (pcl_wr)            pc_o   <= wdata;
         if (stra_edge)         lat_q  <= pc_i;

         if (!out_hs)           olvl_q <= 1'b0;
         else if (pcl_wr)       olvl_q <= 1'b1;
         else if (stra_edge)    olvl_q <= 1'b0;
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < DATA_W; gi++) begin : g_oe
         assign pc_oe[gi] = (out_hs & stra_act) | ddr_q[gi];
      end
   endgenerate

   always_comb begin
      rdata = '0;
      unique case (addr)
         REG_CTRL: begin
            rdata[CTRL_BITS-1:0] = ctrl_q;
            rdata[DATA_W-1]      = flag;
         end
         REG_OUTB: rdata = pb_o;
         REG_PCL:  rdata = lat_q;
         REG_DIRC: rdata = ddr_q;
         default:  rdata = '0;
      endcase
   end

   assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stra_edge |=> (lat_q == $past(pc_i)));

   assert_outb_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pb_wr |=> (pb_o == $past(wdata)));

   assert_olvl_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_hs && stra_edge && !pcl_wr) |=> !olvl_q);

endmodule

// File: tb/pio_strobe_hs_bench.sv
module pio_strobe_hs_bench;

   localparam int DW   = 8;
   localparam int SYNC = 3;
   localparam int PULS = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    addr = '0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata, pc_o, pc_oe, pb_o;
   logic [DW-1:0] pc_i = '0;
   logic          stra_i = 1'b0;
   logic          strb_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pio_strobe_hs #(.DATA_W(DW), .SYNC_STAGES(SYNC), .PULSE_CYCLES(PULS)) u_pio_strobe_hs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .pc_i(pc_i), .pc_o(pc_o), .pc_oe(pc_oe),
      .pb_o(pb_o), .stra_i(stra_i), .strb_o(strb_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic set_stra(input logic v);
      @(negedge clk);
      stra_i = v;
      repeat (SYNC + 2) @(negedge clk);
   endtask

   task automatic expect_pulse(input string req);
      for (int i = 0; i < PULS; i++) begin
         check(req, strb_o, 1'b1);
         @(negedge clk);
      end
      check(req, strb_o, 1'b0);
   endtask

   task automatic t_reset;
      logic [DW-1:0] d;
      bus_rd(2'd0, d); check("R1 ctrl", d, 8'h00);
      bus_rd(2'd3, d); check("R1 ddr", d, 8'h00);
      check("R1 pb", pb_o, 8'h00);
      check("R1 oe", pc_oe, 8'h00);
      check("R1 strb", strb_o, 1'b0);
   endtask

   task automatic t_ctrl;
      logic [DW-1:0] d;
      bus_wr(2'd0, 8'h7F);
      bus_rd(2'd0, d); check("R2 ctrl readback", d, 8'h0F);
      bus_wr(2'd0, 8'h08);
      bus_rd(2'd0, d); check("R2 ctrl rising", d, 8'h08);
   endtask

   task automatic t_simple_capture;
      logic [DW-1:0] d;
      pc_i = 8'hA5;
      set_stra(1'b1);
      bus_rd(2'd0, d); check("R3 flag set", d[7], 1'b1);
      bus_wr(2'd1, 8'h01);
      repeat (PULS + 1) @(negedge clk);
      bus_rd(2'd2, d); check("R3 latch", d, 8'hA5);
      bus_rd(2'd0, d); check("R6 flag kept after cancel", d[7], 1'b1);
      bus_rd(2'd2, d);
      bus_rd(2'd0, d); check("R5 flag cleared", d[7], 1'b0);
      pc_i = 8'h3C;
      set_stra(1'b0);
      bus_rd(2'd0, d); check("R3 inactive edge flag", d[7], 1'b0);
      bus_rd(2'd2, d); check("R3 inactive edge latch", d, 8'hA5);
      bus_rd(2'd2, d);
      bus_rd(2'd0, d); check("R5 unarmed read no clear", d[7], 1'b0);
   endtask

   task automatic t_simple_pulse;
      bus_wr(2'd1, 8'h5A);
      check("R4 pb data", pb_o, 8'h5A);
      expect_pulse("R4 pulse");
   endtask

   task automatic t_input_level;
      logic [DW-1:0] d;
      bus_wr(2'd3, 8'h0F);
      bus_wr(2'd0, 8'h09);
      check("R8 oe follows ddr", pc_oe, 8'h0F);
      check("R9 ready level", strb_o, 1'b1);
      pc_i = 8'h11;
      set_stra(1'b1);
      check("R9 level drops on flag", strb_o, 1'b0);
      check("R8 input mode oe", pc_oe, 8'h0F);
      set_stra(1'b0);
      bus_rd(2'd2, d); check("R5 latch input hs", d, 8'h11);
      bus_rd(2'd0, d); check("R5 unarmed read kept flag", d[7], 1'b1);
      bus_rd(2'd2, d);
      check("R9 level back", strb_o, 1'b1);
      bus_rd(2'd0, d); check("R5 input hs cleared", d[7], 1'b0);
   endtask

   task automatic t_input_pulse;
      logic [DW-1:0] d;
      bus_wr(2'd0, 8'h0D);
      pc_i = 8'h22;
      set_stra(1'b1);
      set_stra(1'b0);
      bus_rd(2'd0, d); check("R3 flag input pulse", d[7], 1'b1);
      check("R9 no pulse yet", strb_o, 1'b0);
      bus_rd(2'd2, d);
      expect_pulse("R9 input clear pulse");
      bus_wr(2'd1, 8'h66);
      check("R10 pb input hs", pb_o, 8'h66);
      check("R10 no strobe", strb_o, 1'b0);
      @(negedge clk); check("R10 no strobe later", strb_o, 1'b0);
   endtask

   task automatic t_output_level;
      logic [DW-1:0] d;
      bus_wr(2'd0, 8'h0B);
      check("R8 oe idle", pc_oe, 8'h0F);
      bus_wr(2'd2, 8'hC3);
      check("R9 out level set", strb_o, 1'b1);
      check("R9 pc data", pc_o, 8'hC3);
      set_stra(1'b1);
      check("R8 forced drive", pc_oe, 8'hFF);
      check("R9 out level ack", strb_o, 1'b0);
      bus_rd(2'd0, d); check("R7 flag set", d[7], 1'b1);
      bus_rd(2'd2, d);
      bus_rd(2'd0, d); check("R7 read does not clear", d[7], 1'b1);
      bus_wr(2'd2, 8'h3C);
      bus_rd(2'd0, d); check("R7 write clears", d[7], 1'b0);
      set_stra(1'b0);
      check("R8 release", pc_oe, 8'h0F);
   endtask

   task automatic t_output_pulse;
      bus_wr(2'd0, 8'h0F);
      bus_wr(2'd2, 8'h99);
      expect_pulse("R9 out write pulse");
      bus_wr(2'd1, 8'h77);
      check("R10 pb output hs", pb_o, 8'h77);
      check("R10 no strobe out", strb_o, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_ctrl;
      t_simple_capture;
      t_simple_pulse;
      t_input_level;
      t_input_pulse;
      t_output_level;
      t_output_pulse;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule